// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog peripheral built around an 8-bit up-counter. It advances on an external clock-enable strobe and is controlled through two small registers on a simple register bus. Software must keep rewriting the counter so that it never wraps. If the counter does wrap while watchdog mode is selected, the block sets a sticky overflow flag. It then drives a fixed-length external overflow pulse. It can also drive a longer internal reset pulse, and that pulse can be either a power-on or a manual reset.

Writes are guarded by a key byte. A write takes effect only as a 16-bit word access whose upper byte is a recognised key. The counter and the control register share one word address, and the key decides which of them receives the lower byte. The reset-control register sits at a second word address and has two separate keyed operations. One clears the overflow flag. The other loads the reset-enable and reset-select bits. Reads are byte accesses and are decoded combinationally from the byte address.

When the internal reset is a power-on reset, it clears the counter and the control register for as long as it is held. The flag and the reset-control bits survive it, so software can still read the cause of the reset.

Top module: `keyed_wdog`

## Requirements
- R1: After the synchronous reset, every register reads 0x00 and `wdt_ovf`, `rst_por` and `rst_manual` are low.
- R2: A word write to byte address 0 with upper byte 0x5A loads the lower byte into the counter. With upper byte 0xA5, the same write loads the lower byte into the control register. Both take effect at the next clock edge.
- R3: A byte write, a word write to address 1 or 3, or a word write whose upper byte is not an accepted key changes no register. The same holds for a write of 0xA5 with a nonzero lower byte to address 2.
- R4: A word write of exactly 0xA500 to byte address 2 clears the overflow flag and leaves the reset-enable and reset-select bits unchanged.
- R5: A word write to byte address 2 with upper byte 0x5A copies data bit 6 into reset-enable and data bit 5 into reset-select. The flag is left unchanged.
- R6: `bus_rdata` shows the selected register combinationally. Address 0 gives the control byte and address 1 the counter. Address 3 gives the reset-control byte, with flag in bit 7, reset-enable in bit 6, reset-select in bit 5 and zeros below. Address 2 reads 0x00.
- R7: Control bit 0 is the run bit. While it is 1, each cycle with `tick` high increments the counter, and the counter wraps from 0xFF to 0x00. While it is 0 the counter holds. A counter write in the same cycle as a tick takes priority over the tick.
- R8: Control bit 1 is the watchdog-mode bit. A wrap while this bit and the run bit are both 1 sets the flag and raises `wdt_ovf` at the next edge for exactly 128 cycles. A wrap with the mode bit at 0 sets nothing.
- R9: If reset-enable is 1 at a watchdog wrap, an internal reset rises together with `wdt_ovf` and lasts 512 cycles. Reset-select 0 drives `rst_por` and reset-select 1 drives `rst_manual`. The two outputs are never high together, and reset-enable 0 drives neither.
- R10: While `rst_por` is high, the counter and the control register are held at 0x00 and writes to them are lost. The flag, reset-enable and reset-select keep their values.
- R11: A manual internal reset leaves the counter and control register alone, so counting goes on. A further watchdog wrap restarts both pulses at full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Counter clock-enable strobe |
| bus_wr | input | 1 | Write strobe |
| bus_word | input | 1 | 1 = 16-bit word access, 0 = byte access |
| bus_addr | input | 2 | Byte address within the block |
| bus_wdata | input | 16 | Write data; upper byte is the key |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| wdt_ovf | output | 1 | External overflow pulse |
| rst_por | output | 1 | Internal power-on reset pulse |
| rst_manual | output | 1 | Internal manual reset pulse |

## Verification
A write or a tick presented before a clock edge is visible on `bus_rdata` just after that edge. A watchdog wrap raises `wdt_ovf` and the selected internal reset one edge later, and the reset's effect on the counter and control register shows one edge after that. The bench's behavioural model advances at each rising edge from the same inputs. It compares every output one nanosecond after the edge, and the stimulus only changes on falling edges. Pulse lengths are measured by counting consecutive high samples, so they can be compared exactly with 128 and 512.

// File: rtl/kwd_pkg.sv
package kwd_pkg;

    localparam logic [7:0]  KEY_DATA   = 8'h5A;
    localparam logic [7:0]  KEY_ALT    = 8'hA5;
    localparam logic [15:0] FLAG_CLEAR = 16'hA500;

    typedef struct packed {
        logic [5:0] spare;
        logic       wd_mode;
        logic       run;
    } ctrl_t;

    typedef struct packed {
        logic       flag;
        logic       en;
        logic       sel;
        logic [4:0] pad;
    } rctl_t;

    typedef enum logic [2:0] {
        WR_NONE,
        WR_CNT,
        WR_CTRL,
        WR_FLAGCLR,
        WR_RSTBITS
    } wr_kind_e;

    function automatic wr_kind_e decode_write(input logic        strobe,
                                              input logic        word,
                                              input logic [1:0]  addr,
                                              input logic [15:0] data);
        wr_kind_e k;
        k = WR_NONE;
        if (strobe && word) begin
            if (addr == 2'd0) begin
                if (data[15:8] == KEY_DATA)     k = WR_CNT;
                else if (data[15:8] == KEY_ALT) k = WR_CTRL;
            end else if (addr == 2'd2) begin
                if (data == FLAG_CLEAR)          k = WR_FLAGCLR;
                else if (data[15:8] == KEY_DATA) k = WR_RSTBITS;
            end
        end
        return k;
    endfunction

    function automatic logic [7:0] read_mux(input logic [1:0] addr,
                                            input ctrl_t      ctrl,
                                            input logic [7:0] cnt,
                                            input rctl_t      rctl);
        logic [7:0] v;
        case (addr)
            2'd0:    v = ctrl;
            2'd1:    v = cnt;
            2'd3:    v = {rctl.flag, rctl.en, rctl.sel, 5'b0};
            default: v = 8'h00;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/kwd_counter.sv
module kwd_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick,
    input  logic         run,
    input  logic         wd_mode,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         wd_wrap
);
    logic step;
    logic wrap;

    assign step    = tick && run;
    assign wrap    = step && (cnt == {W{1'b1}});
    assign wd_wrap = wrap && wd_mode;

    always_ff @(posedge clk) begin
        if (rst || clr)  cnt <= '0;
        else if (load)   cnt <= load_val;
        else if (step)   cnt <= cnt + 1'b1;
    end

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !load && !clr) |=> $stable(cnt));

endmodule

// File: rtl/kwd_regs.sv
module kwd_regs
    import kwd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  wr_kind_e   kind,
    input  logic [7:0] wdata,
    input  logic       ovf_evt,
    output ctrl_t      ctrl,
    output rctl_t      rctl
);
    always_ff @(posedge clk) begin
        if (rst || clr)           ctrl <= '0;
        else if (kind == WR_CTRL) ctrl <= ctrl_t'(wdata);
    end

    always_ff @(posedge clk) begin
        if (rst)                     rctl.flag <= 1'b0;
        else if (ovf_evt)            rctl.flag <= 1'b1;
        else if (kind == WR_FLAGCLR) rctl.flag <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rctl.en  <= 1'b0;
            rctl.sel <= 1'b0;
        end else if (kind == WR_RSTBITS) begin
            rctl.en  <= wdata[6];
            rctl.sel <= wdata[5];
        end
    end

    assign rctl.pad = '0;

    // R4
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (kind == WR_FLAGCLR && !ovf_evt) |=> (!rctl.flag && $stable(rctl.en) && $stable(rctl.sel)));

endmodule

// File: rtl/kwd_stretch.sv
module kwd_stretch #(
    parameter int LEN = 128
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic active
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] left;

    always_ff @(posedge clk) begin
        if (rst)              left <= '0;
        else if (trig)        left <= CW'(LEN);
        else if (left != '0)  left <= left - 1'b1;
    end

    assign active = (left != '0);

    // R8
    trig_act_chk: assert property (@(posedge clk) disable iff (rst)
        trig |=> active);

endmodule

// File: rtl/keyed_wdog.sv
module keyed_wdog
    import kwd_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int EXT_LEN = 128,
    parameter int INT_LEN = 512
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        bus_wr,
    input  logic        bus_word,
    input  logic [1:0]  bus_addr,
    input  logic [15:0] bus_wdata,
    output logic [7:0]  bus_rdata,
    output logic        wdt_ovf,
    output logic        rst_por,
    output logic        rst_manual
);
    wr_kind_e         kind;
    ctrl_t            ctrl;
    rctl_t            rctl;
    logic [CNT_W-1:0] cnt;
    logic             wd_wrap;
    logic             int_trig;
    logic             int_act;
    logic             int_manual;

    assign kind = decode_write(bus_wr, bus_word, bus_addr, bus_wdata);

    kwd_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .clr      (rst_por),
        .tick     (tick),
        .run      (ctrl.run),
        .wd_mode  (ctrl.wd_mode),
        .load     (kind == WR_CNT),
        .load_val (bus_wdata[CNT_W-1:0]),
        .cnt      (cnt),
        .wd_wrap  (wd_wrap)
    );

    kwd_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .clr     (rst_por),
        .kind    (kind),
        .wdata   (bus_wdata[7:0]),
        .ovf_evt (wd_wrap),
        .ctrl    (ctrl),
        .rctl    (rctl)
    );

    assign int_trig = wd_wrap && rctl.en;

    kwd_stretch #(.LEN(EXT_LEN)) u_ext (
        .clk    (clk),
        .rst    (rst),
        .trig   (wd_wrap),
        .active (wdt_ovf)
    );

    kwd_stretch #(.LEN(INT_LEN)) u_int (
        .clk    (clk),
        .rst    (rst),
        .trig   (int_trig),
        .active (int_act)
    );

    always_ff @(posedge clk) begin
        if (rst)           int_manual <= 1'b0;
        else if (int_trig) int_manual <= rctl.sel;
    end

    assign rst_por    = int_act && !int_manual;
    assign rst_manual = int_act &&  int_manual;

    assign bus_rdata = read_mux(bus_addr, ctrl, 8'(cnt), rctl);

    // R8
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        wd_wrap |=> (wdt_ovf && rctl.flag));

    // R9
    rst_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rst_por && rst_manual));

    // R9
    rst_with_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(rst_por) || $rose(rst_manual)) |-> wdt_ovf);

    // R10
    por_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rst_por |=> (cnt == '0 && ctrl == '0));

    // R3
    byte_wr_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_word && !rst_por) |=> $stable(ctrl));

endmodule

// File: tb/keyed_wdog_bench.sv
module keyed_wdog_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_word = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [7:0]  bus_rdata;
    logic        wdt_ovf, rst_por, rst_manual;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    keyed_wdog u_keyed_wdog (
        .clk(clk), .rst(rst), .tick(tick), .bus_wr(bus_wr), .bus_word(bus_word),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wdt_ovf(wdt_ovf), .rst_por(rst_por), .rst_manual(rst_manual)
    );

    // behavioural reference model
    int m_cnt, m_ctrl, m_flag, m_en, m_sel, m_ext, m_int, m_isel;

    always @(posedge clk) begin
        bit evt, por_now;
        if (rst) begin
            m_cnt = 0; m_ctrl = 0; m_flag = 0; m_en = 0; m_sel = 0;
            m_ext = 0; m_int = 0; m_isel = 0;
        end else begin
            bit run, wd, wcnt, wctrl, wclr, wbits;
            run   = m_ctrl[0];
            wd    = m_ctrl[1];
            wcnt  = bus_wr && bus_word && bus_addr == 0 && bus_wdata[15:8] == 8'h5A;
            wctrl = bus_wr && bus_word && bus_addr == 0 && bus_wdata[15:8] == 8'hA5;
            wclr  = bus_wr && bus_word && bus_addr == 2 && bus_wdata == 16'hA500;
            wbits = bus_wr && bus_word && bus_addr == 2 && bus_wdata[15:8] == 8'h5A;
            evt     = tick && run && wd && m_cnt == 255;
            por_now = m_int > 0 && m_isel == 0;
            if (m_int > 0) m_int = m_int - 1;
            if (evt && m_en) begin m_int = 512; m_isel = m_sel; end
            if (m_ext > 0) m_ext = m_ext - 1;
            if (evt) m_ext = 128;
            if (evt) m_flag = 1; else if (wclr) m_flag = 0;
            if (wbits) begin m_en = bus_wdata[6]; m_sel = bus_wdata[5]; end
            if (por_now) m_cnt = 0;
            else if (wcnt) m_cnt = bus_wdata[7:0];
            else if (tick && run) m_cnt = (m_cnt + 1) % 256;
            if (por_now) m_ctrl = 0;
            else if (wctrl) m_ctrl = bus_wdata[7:0];
        end
    end

    function automatic int model_read(input logic [1:0] a);
        case (a)
            2'd0: return m_ctrl;
            2'd1: return m_cnt;
            2'd3: return (m_flag << 7) | (m_en << 6) | (m_sel << 5);
            default: return 0;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    int ext_run = 0, por_run = 0, man_run = 0;
    int last_ext = 0, last_por = 0, last_man = 0;

    // per-cycle comparison, 1 ns after each rising edge
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            chk("R8 wdt_ovf", int'(wdt_ovf), int'(m_ext > 0));
            chk("R9 rst_por", int'(rst_por), int'(m_int > 0 && m_isel == 0));
            chk("R9 rst_manual", int'(rst_manual), int'(m_int > 0 && m_isel == 1));
            chk("R6 bus_rdata", int'(bus_rdata), model_read(bus_addr));
        end
        if (wdt_ovf) ext_run++; else if (ext_run > 0) begin last_ext = ext_run; ext_run = 0; end
        if (rst_por) por_run++; else if (por_run > 0) begin last_por = por_run; por_run = 0; end
        if (rst_manual) man_run++; else if (man_run > 0) begin last_man = man_run; man_run = 0; end
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic word = 1'b1);
        @(negedge clk);
        bus_wr = 1'b1; bus_word = word; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_word = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output int v);
        @(negedge clk);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    bit done = 0;

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(0, v); chk("R1 ctrl", v, 0);
        rd(1, v); chk("R1 cnt", v, 0);
        rd(3, v); chk("R1 rctl", v, 0);
        chk("R1 outputs", int'({wdt_ovf, rst_por, rst_manual}), 0);

        // R2 keyed loads
        wr(0, 16'h5A37); rd(1, v); chk("R2 cnt load", v, 8'h37);
        wr(0, 16'hA5F0); rd(0, v); chk("R2 ctrl load", v, 8'hF0);

        // R3 ignored writes
        wr(0, 16'h1234);
        wr(0, 16'h5A99, 1'b0);
        wr(0, 16'hA50C, 1'b0);
        wr(1, 16'h5A11);
        wr(3, 16'h5A60);
        wr(2, 16'hA501);
        rd(1, v); chk("R3 cnt kept", v, 8'h37);
        rd(0, v); chk("R3 ctrl kept", v, 8'hF0);
        rd(3, v); chk("R3 rctl kept", v, 0);
        rd(2, v); chk("R6 addr2 zero", v, 0);

        // R7 counting in interval mode, wrap, hold
        wr(0, 16'hA501);
        wr(0, 16'h5AFE);
        ticks(3);
        rd(1, v); chk("R7 wrap count", v, 8'h01);
        rd(3, v); chk("R8 no flag in interval mode", v, 0);
        chk("R8 no pulse in interval mode", last_ext, 0);
        wr(0, 16'hA500);
        ticks(5);
        rd(1, v); chk("R7 hold when run=0", v, 8'h01);

        // R5 reset bits
        wr(2, 16'h5A60);
        rd(3, v); chk("R5 en/sel load", v, 8'h60);

        // R9 / R11 manual reset
        wr(0, 16'h5AFD);
        wr(0, 16'hA503);
        ticks(3);
        idle(600);
        chk("R8 ext length", last_ext, 128);
        chk("R9 manual length", last_man, 512);
        chk("R9 no por", last_por, 0);
        rd(3, v); chk("R8 flag set", v, 8'hE0);
        rd(0, v); chk("R11 ctrl kept", v, 8'h03);
        rd(1, v); chk("R11 cnt after wrap", v, 8'h00);

        // R11 retrigger extends the manual reset
        wr(0, 16'h5AFF); ticks(1);
        idle(200);
        wr(0, 16'h5AFF); ticks(1);
        idle(800);
        chk("R11 retrigger longer", int'(last_man > 512 && last_man < 800), 1);
        chk("R11 ext after retrigger", last_ext, 128);

        // R4 flag clear keeps en/sel
        wr(2, 16'hA500);
        rd(3, v); chk("R4 flag cleared", v, 8'h60);

        // R9 / R10 power-on reset
        wr(2, 16'h5A40);
        rd(3, v); chk("R5 sel=0", v, 8'h40);
        wr(0, 16'h5AFF);
        wr(0, 16'hA503);
        ticks(1);
        idle(50);
        chk("R9 por active", int'(rst_por), 1);
        wr(0, 16'h5A22);
        wr(0, 16'hA503);
        rd(1, v); chk("R10 cnt held", v, 0);
        rd(0, v); chk("R10 ctrl held", v, 0);
        idle(600);
        chk("R9 por length", last_por, 512);
        chk("R8 ext length por", last_ext, 128);
        rd(3, v); chk("R10 cause kept", v, 8'hC0);
        rd(0, v); chk("R10 ctrl cleared", v, 0);

        // R9 reset-enable 0: pulse without internal reset
        wr(2, 16'h5A00);
        wr(2, 16'hA500);
        wr(0, 16'h5AFF);
        wr(0, 16'hA503);
        last_por = 0; last_man = 0;
        ticks(1);
        idle(200);
        chk("R9 no por when disabled", last_por, 0);
        chk("R9 no manual when disabled", last_man, 0);
        chk("R8 ext length no reset", last_ext, 128);
        rd(3, v); chk("R8 flag only", v, 8'h80);

        idle(4);
        done = 1;
    end

    initial begin
        int n;
        n = 0;
        while (!done && n < 50000) begin
            @(posedge clk);
            n++;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=done", n);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule